// File: doc/BRIEF.md
# Dual-Stream Address Request Concentrator

This block gathers read addresses from a large set of requesters on a slow compute clock and passes them to a faster memory-controller clock. The requesters form two equal groups. Each group has its own round-robin arbiter. In every slow cycle each arbiter may accept one request and returns a one-cycle grant to the requester it picked. The two accepted addresses are stored together, as one double-width entry, in a dual-clock FIFO. A single slow-side entry can therefore carry two addresses.

The fast side takes entries one 32-bit address at a time through a valid/ready port. When only one group had a request in a cycle, the empty half of the entry is marked invalid and the read side skips it. Read and write pointers cross between the clock domains as Gray codes through two-flop synchronizers. The arbiters stop granting while the FIFO is full, so no request is lost and none is granted twice.

Top module: `addr_concentrator`

## Requirements
- R1: While `wr_rst_n` is low, no `gnt` bit is set, even when requests are present. After both resets have been released and before any request, `out_valid` is 0.
- R2: In each slow cycle at most one `gnt` bit per group is set. A grant goes only to a requester whose `req` bit is high, and it lasts one slow cycle. Requester i of group s uses `req[s*N+i]`, `gnt[s*N+i]` and `addr[(s*N+i)*32 +: 32]`; group 0 is the lower half.
- R3: Arbitration is round robin inside each group. The search starts at the index just above the last one granted and wraps from N-1 to 0. A requester cannot win twice in a row while another requester in its group is waiting. After reset the search starts at index 0.
- R4: When both groups have a request in the same slow cycle, both are granted in that cycle and their addresses are stored as one FIFO entry.
- R5: Addresses leave in the order their entries were written. Within one entry, the group-0 address leaves before the group-1 address.
- R6: When only one group is granted in a cycle, the other half of the entry is marked invalid. That half is never presented on `out_addr`, and no output cycle is spent on it.
- R7: While the FIFO holds 2^FIFO_DEPTH_LOG entries (8 by default) that have not been read, no grant is given.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_addr` does not change.
- R9: Every granted address is delivered exactly once on the fast clock, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Slow compute-side clock |
| wr_rst_n | input | 1 | Synchronous active-low reset, slow domain |
| req | input | 2*N_PER_STREAM | Request flags; lower half is group 0 |
| addr | input | 2*N_PER_STREAM*ADDR_W | Address per requester, packed by index |
| gnt | output | 2*N_PER_STREAM | One-cycle grant to the winning requester |
| rd_clk | input | 1 | Fast memory-side clock |
| rd_rst_n | input | 1 | Synchronous active-low reset, fast domain |
| out_valid | output | 1 | An address is presented on out_addr |
| out_ready | input | 1 | Memory side accepts out_addr this cycle |
| out_addr | output | ADDR_W | Address toward the memory controller |

## Verification
The assertions assume that a requester keeps its `req` high and its address steady until it sees its grant, and then drops the request, so a grant always stands for exactly one accepted address. They also assume both resets are applied together and held for several cycles of each clock, so the pointers start equal. The bench drives requests only on falling slow-clock edges, one address per requester at a time, and drops each request on the edge after its grant. It changes `out_ready` only between fast-clock edges, so every handshake it counts is the one the design sees.

// File: rtl/conc_pkg.sv
// Shared definitions for the address concentrator.
// Assumes exactly two arbitration streams share one FIFO entry.
package conc_pkg;
    localparam int unsigned STREAMS = 2;

    // Which half of the current FIFO entry the read side is presenting.
    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;
endpackage

// File: rtl/conc_rr_arb.sv
// Round-robin picker for one group of requesters.
// Picks at most one requester per cycle, starting the search just above the
// last winner. Assumes N is a power of two and at least 2. The grant is
// combinational and is valid only while hold is low.
module conc_rr_arb #(
    parameter int unsigned N  = 32,
    parameter int unsigned AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hold,
    input  logic [N-1:0]    req,
    input  logic [N*AW-1:0] addr,
    output logic [N-1:0]    gnt,
    output logic            pick_vld,
    output logic [AW-1:0]   pick_addr
);
    localparam int unsigned IW = $clog2(N);

    logic [IW-1:0] last_q;
    logic [IW-1:0] win;
    logic          found;

    // Search the requests in rotating order, starting after the last winner.
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 1; k <= int'(N); k++) begin
            logic [IW-1:0] cand;
            cand = last_q + IW'(k);
            if (!found && req[cand]) begin
                found = 1'b1;
                win   = cand;
            end
        end
    end

    // Turn the winner into a grant and select its address.
    always_comb begin
        gnt       = '0;
        pick_vld  = found && !hold;
        pick_addr = addr[int'(win)*int'(AW) +: AW];
        if (pick_vld) gnt[win] = 1'b1;
    end

    // Remember the last winner; after reset the search starts at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_q <= IW'(N - 1);
        else if (pick_vld) last_q <= win;
    end

    // R2
    gnt_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~req) == '0);

    // R3
    rr_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_vld && $past(pick_vld) && gnt == $past(gnt)) |-> $countones(req) == 1);
endmodule

// File: rtl/conc_sync2.sv
// Two-flop synchronizer for a vector of Gray-coded bits.
// Assumes at most one bit of the input changes between destination edges.
module conc_sync2 #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Pass the input through two destination-domain flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/conc_async_fifo.sv
// Dual-clock FIFO with a two-lane write port and a one-lane read port.
// Each entry holds two addresses, each with its own valid flag. The read side
// presents the low lane first and the high lane second, and skips lanes marked
// invalid. Assumes every push carries at least one valid lane and that
// DL >= 2. Pointers cross the domains in Gray code.
module conc_async_fifo
    import conc_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DL = 3
) (
    input  logic          wr_clk,
    input  logic          wr_rst_n,
    input  logic          push,
    input  logic          lo_vld,
    input  logic [AW-1:0] lo_addr,
    input  logic          hi_vld,
    input  logic [AW-1:0] hi_addr,
    output logic          full,
    input  logic          rd_clk,
    input  logic          rd_rst_n,
    input  logic          rd_ready,
    output logic          rd_valid,
    output logic [AW-1:0] rd_addr
);
    localparam int unsigned DEPTH = 1 << DL;
    localparam int unsigned PW    = DL + 1;
    localparam int unsigned EW    = 2 * (AW + 1);

    function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
        return b ^ (b >> 1);
    endfunction

    logic [EW-1:0] mem_q [DEPTH];
    logic [PW-1:0] wbin_q, wgray_q, rgray_in_w;
    logic [PW-1:0] rbin_q, rgray_q, wgray_in_r;
    logic          wr_fire;
    lane_e         lane_q;
    logic [EW-1:0] cur;
    logic          cur_lo_vld, cur_hi_vld, use_hi, rd_empty, take, pop;

    // Full when the write pointer is one lap ahead of the synchronized read pointer.
    always_comb begin
        full    = ((wgray_q ^ rgray_in_w) == {2'b11, {(PW-2){1'b0}}});
        wr_fire = push && !full;
    end

    // Store both lanes of an accepted entry.
    always_ff @(posedge wr_clk) begin
        if (wr_fire) mem_q[wbin_q[DL-1:0]] <= {hi_vld, hi_addr, lo_vld, lo_addr};
    end

    // Advance the write pointer in binary and Gray form.
    always_ff @(posedge wr_clk) begin
        if (!wr_rst_n) begin
            wbin_q  <= '0;
            wgray_q <= '0;
        end else if (wr_fire) begin
            wbin_q  <= wbin_q + 1'b1;
            wgray_q <= to_gray(wbin_q + 1'b1);
        end
    end

    conc_sync2 #(.W(PW)) u_rptr_sync (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rgray_q), .q(rgray_in_w));

    conc_sync2 #(.W(PW)) u_wptr_sync (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wgray_q), .q(wgray_in_r));

    // Decode the head entry and choose which lane to present.
    always_comb begin
        cur        = mem_q[rbin_q[DL-1:0]];
        cur_lo_vld = cur[AW];
        cur_hi_vld = cur[EW-1];
        use_hi     = (lane_q == LANE_HI) || !cur_lo_vld;
        rd_empty   = (rgray_q == wgray_in_r);
        rd_valid   = !rd_empty;
        rd_addr    = use_hi ? cur[EW-2:AW+1] : cur[AW-1:0];
        take       = rd_valid && rd_ready;
        pop        = take && (use_hi || !cur_hi_vld);
    end

    // Step through the lanes and retire the entry after its last valid lane.
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            lane_q  <= LANE_LO;
        end else if (pop) begin
            rbin_q  <= rbin_q + 1'b1;
            rgray_q <= to_gray(rbin_q + 1'b1);
            lane_q  <= LANE_LO;
        end else if (take) begin
            lane_q  <= LANE_HI;
        end
    end

    // R7
    no_overflow_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        push |-> !full);

    // R6
    push_has_lane_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        push |-> (lo_vld || hi_vld));

    // R8
    hold_stable_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

    // R9
    wgray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        $countones(wgray_q ^ $past(wgray_q)) <= 1);

    // R9
    rgray_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        $countones(rgray_q ^ $past(rgray_q)) <= 1);
endmodule

// File: rtl/addr_concentrator.sv
// Top level: two round-robin pickers feed one two-lane dual-clock FIFO.
// Group 0 is the lower half of req and fills the low lane, which is read
// first. Assumes requesters hold req and addr until granted, and that both
// resets are applied together.
module addr_concentrator
    import conc_pkg::*;
#(
    parameter int unsigned N_PER_STREAM   = 32,
    parameter int unsigned ADDR_W         = 32,
    parameter int unsigned FIFO_DEPTH_LOG = 3
) (
    input  logic                                 wr_clk,
    input  logic                                 wr_rst_n,
    input  logic [STREAMS*N_PER_STREAM-1:0]        req,
    input  logic [STREAMS*N_PER_STREAM*ADDR_W-1:0] addr,
    output logic [STREAMS*N_PER_STREAM-1:0]        gnt,
    input  logic                                 rd_clk,
    input  logic                                 rd_rst_n,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [ADDR_W-1:0]                    out_addr
);
    localparam int unsigned GW = N_PER_STREAM * ADDR_W;

    logic                fifo_full;
    logic                arb_hold;
    logic [STREAMS-1:0]  pick_vld;
    logic [ADDR_W-1:0]   pick_addr [STREAMS];

    // Block grants during reset and while the FIFO cannot take an entry.
    always_comb arb_hold = fifo_full || !wr_rst_n;

    for (genvar s = 0; s < STREAMS; s++) begin : g_stream
        conc_rr_arb #(.N(N_PER_STREAM), .AW(ADDR_W)) u_arb (
            .clk       (wr_clk),
            .rst_n     (wr_rst_n),
            .hold      (arb_hold),
            .req       (req[s*N_PER_STREAM +: N_PER_STREAM]),
            .addr      (addr[s*GW +: GW]),
            .gnt       (gnt[s*N_PER_STREAM +: N_PER_STREAM]),
            .pick_vld  (pick_vld[s]),
            .pick_addr (pick_addr[s])
        );
    end

    conc_async_fifo #(.AW(ADDR_W), .DL(FIFO_DEPTH_LOG)) u_fifo (
        .wr_clk   (wr_clk),
        .wr_rst_n (wr_rst_n),
        .push     (|pick_vld),
        .lo_vld   (pick_vld[0]),
        .lo_addr  (pick_addr[0]),
        .hi_vld   (pick_vld[1]),
        .hi_addr  (pick_addr[1]),
        .full     (fifo_full),
        .rd_clk   (rd_clk),
        .rd_rst_n (rd_rst_n),
        .rd_ready (out_ready),
        .rd_valid (out_valid),
        .rd_addr  (out_addr)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge wr_clk)
        !wr_rst_n |-> (gnt == '0));
endmodule

// File: tb/sim_addr_concentrator.sv
module sim_addr_concentrator;
    localparam int N  = 32;
    localparam int AW = 32;
    localparam int DEPTH = 8;

    logic              wr_clk = 1'b0;
    logic              rd_clk = 1'b0;
    logic              wr_rst_n = 1'b0;
    logic              rd_rst_n = 1'b0;
    logic [2*N-1:0]    req = '0;
    logic [2*N*AW-1:0] addr = '0;
    logic [2*N-1:0]    gnt;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [AW-1:0]     out_addr;

    int checks = 0;
    int fails  = 0;
    logic [AW-1:0] exp_q [256];
    logic [AW-1:0] got_q [256];
    int nexp = 0;
    int ngot = 0;

    // Vector: {group0 enable, group0 index, group1 enable, group1 index}
    localparam logic [11:0] VEC [12] = '{
        {1'b1, 5'd0,  1'b1, 5'd0},
        {1'b1, 5'd5,  1'b1, 5'd31},
        {1'b1, 5'd7,  1'b0, 5'd0},
        {1'b0, 5'd0,  1'b1, 5'd9},
        {1'b0, 5'd0,  1'b0, 5'd0},
        {1'b1, 5'd31, 1'b1, 5'd1},
        {1'b1, 5'd31, 1'b0, 5'd0},
        {1'b0, 5'd0,  1'b1, 5'd0},
        {1'b1, 5'd12, 1'b1, 5'd12},
        {1'b1, 5'd3,  1'b0, 5'd0},
        {1'b1, 5'd30, 1'b1, 5'd2},
        {1'b0, 5'd0,  1'b1, 5'd31}
    };

    always #5 wr_clk = ~wr_clk;
    always #2 rd_clk = ~rd_clk;

    addr_concentrator u0 (
        .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .req(req), .addr(addr), .gnt(gnt),
        .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .out_valid(out_valid),
        .out_ready(out_ready), .out_addr(out_addr));

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_ready(input logic v);
        @(posedge rd_clk);
        #1 out_ready = v;
    endtask

    task automatic drain();
        for (int i = 0; i < 3000 && ngot != nexp; i++) @(posedge rd_clk);
        repeat (10) @(posedge rd_clk);
    endtask

    // Record every accepted output, sampled between fast-clock edges.
    always @(negedge rd_clk) begin
        if (rd_rst_n && out_valid && out_ready && ngot < 256) begin
            got_q[ngot] = out_addr;
            ngot++;
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", ngot, nexp);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [2*N-1:0] e;
        int accepted;
        logic [AW-1:0] held;

        // R1: requests during reset get no grant
        req = '1;
        repeat (4) @(negedge wr_clk);
        #1 chk(gnt == '0, "R1 grant in reset", 64'(gnt), 64'd0);
        @(negedge wr_clk);
        req = '0;
        #1;
        wr_rst_n = 1'b1;
        rd_rst_n = 1'b1;
        repeat (3) @(negedge rd_clk);
        chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
        set_ready(1'b1);

        // Table walk: R2, R4 grants; R5, R6 order checked at the end
        for (int v = 0; v < 12; v++) begin
            logic [AW-1:0] a0, a1;
            int i0, i1;
            i0 = int'(VEC[v][10:6]);
            i1 = int'(VEC[v][4:0]);
            a0 = 32'h1000_0000 | AW'(v << 8) | AW'(i0);
            a1 = 32'h2000_0000 | AW'(v << 8) | AW'(i1);
            @(negedge wr_clk);
            req = '0;
            e = '0;
            if (VEC[v][11]) begin
                req[i0] = 1'b1;
                addr[i0*AW +: AW] = a0;
                e[i0] = 1'b1;
            end
            if (VEC[v][5]) begin
                req[N+i1] = 1'b1;
                addr[(N+i1)*AW +: AW] = a1;
                e[N+i1] = 1'b1;
            end
            #1 chk(gnt == e, "R2/R4 grant vector", 64'(gnt), 64'(e));
            if (VEC[v][11]) begin exp_q[nexp] = a0; nexp++; end
            if (VEC[v][5])  begin exp_q[nexp] = a1; nexp++; end
        end
        @(negedge wr_clk);
        req = '0;
        drain();

        // R3: all of group 0 request; last winner was 30, so order is 31,0,1,...
        @(negedge wr_clk);
        for (int i = 0; i < N; i++) begin
            req[i] = 1'b1;
            addr[i*AW +: AW] = 32'h3000_0000 + AW'(i);
        end
        for (int k = 0; k < N; k++) begin
            int x;
            x = (31 + k) % N;
            e = '0;
            e[x] = 1'b1;
            #1 chk(gnt == e, "R3 round robin order", 64'(gnt), 64'(e));
            exp_q[nexp] = 32'h3000_0000 + AW'(x);
            nexp++;
            @(negedge wr_clk);
            req[x] = 1'b0;
        end
        req = '0;
        drain();

        // R7: stall the reader and fill the FIFO with group-1-only entries
        set_ready(1'b0);
        repeat (6) @(negedge wr_clk);
        accepted = 0;
        for (int k = 0; k < DEPTH + 4; k++) begin
            @(negedge wr_clk);
            req = '0;
            req[N+4] = 1'b1;
            addr[(N+4)*AW +: AW] = 32'h4000_0000 + AW'(accepted);
            #1;
            if (gnt[N+4]) begin
                exp_q[nexp] = 32'h4000_0000 + AW'(accepted);
                nexp++;
                accepted++;
            end
        end
        #1 chk(gnt == '0, "R7 no grant while full", 64'(gnt), 64'd0);
        chk(accepted == DEPTH, "R7 entries accepted", 64'(accepted), 64'(DEPTH));
        @(negedge wr_clk);
        req = '0;

        // R8: output holds while not ready
        @(negedge rd_clk);
        held = out_addr;
        chk(out_valid == 1'b1, "R8 valid while stalled", 64'(out_valid), 64'd1);
        chk(held == 32'h4000_0000, "R8 head address", 64'(held), 64'h4000_0000);
        repeat (7) @(negedge rd_clk);
        chk(out_valid == 1'b1, "R8 valid still held", 64'(out_valid), 64'd1);
        chk(out_addr == held, "R8 address stable", 64'(out_addr), 64'(held));
        set_ready(1'b1);
        drain();

        // R5, R6, R9: delivered sequence equals expected sequence
        chk(ngot == nexp, "R9 delivered count", 64'(ngot), 64'(nexp));
        for (int i = 0; i < nexp; i++)
            chk(got_q[i] === exp_q[i], "R5/R6/R9 delivered address", 64'(got_q[i]), 64'(exp_q[i]));

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule